// File: doc/BRIEF.md
# Triple-Redundant Toggle Register with Disagreement Flag

This block keeps three redundant copies of a multi-bit toggle register. All three copies share one clock, one synchronous reset and one toggle vector. On each rising edge a bit of every copy inverts when its toggle bit is high. A bank of per-bit multiplexer voters combines the three copies into one protected output. For each bit, two of the copies form the mux select and the third copy breaks the tie.

A second mux per bit reports whether the three copies disagree on that bit. These per-bit flags are OR-reduced into a live mismatch output. A small state machine latches the mismatch into a sticky flag, which a write-one-to-clear input resets. Each copy also has an inversion input that flips that copy's output, but not its stored state. A bench can use it to show that one faulty copy is outvoted, and that two faulty copies on the same bit are not.

Top module: `tmr_toggle_reg`

The sticky flag machine has two states. `ST_CLEAN` moves to `ST_FLAGGED` when the live mismatch is high at a clock edge. `ST_FLAGGED` moves back to `ST_CLEAN` when `clr_flag` is high and the live mismatch is low at the same edge. In every other case it stays where it is. Reset forces `ST_CLEAN`.

## Requirements
- R1: A rising edge with `rst` high clears all three stored copies and the sticky flag. With no inversion applied, `q`, `mismatch` and `mismatch_seen` then read 0.
- R2: On a rising edge with `rst` low, each stored bit of every copy inverts when its `tgl` bit is 1 and holds when it is 0.
- R3: Let the output of copy k be its stored bits XOR its inversion input. Each bit of `q` is then 1 exactly when at least two of the three copy outputs are 1 for that bit.
- R4: When, for every bit, at most one of `inj_a`, `inj_b`, `inj_c` is 1, `q` equals the fault-free register value.
- R5: Inversion inputs change only the copy outputs. Toggling goes on during a fault, and once the inversions return to 0, `q` shows the full toggle history.
- R6: `mismatch` is 1 exactly when some bit has copy outputs that are not all equal. The comparison uses the outputs of copies B and C and, where they agree, copy A.
- R7: When two copies are inverted on the same bit, that bit of `q` reads the inverse of the fault-free value.
- R8: `mismatch_seen` goes to 1 at the first rising edge where `mismatch` is 1. It stays 1 until a rising edge with `clr_flag` high and `mismatch` low.
- R9: If `clr_flag` and `mismatch` are both 1 at an edge, the set wins and `mismatch_seen` stays 1.
- R10: `clr_flag` while `mismatch_seen` is 0 leaves it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst | input | 1 | Synchronous active-high reset |
| tgl | input | W | Per-bit toggle enable, fed to all copies |
| inj_a | input | W | Output inversion mask for copy A |
| inj_b | input | W | Output inversion mask for copy B |
| inj_c | input | W | Output inversion mask for copy C |
| clr_flag | input | 1 | Write-one-to-clear for the sticky flag |
| q | output | W | Majority-voted register value |
| mismatch | output | 1 | Live disagreement among the copies |
| mismatch_seen | output | 1 | Sticky disagreement flag |

## Verification
`q` and `mismatch` depend combinationally on the stored copies and the inversion masks. They are therefore due in the same cycle as a change on an inversion mask, and one rising edge after a toggle. `mismatch_seen` passes through one more register, so it reflects a mismatch one edge after that mismatch is present. The bench drives every input just after a falling edge and samples all outputs one time unit later. Its reference state advances only at the following rising edge, so each sample compares against a model that has seen exactly the edges the design has seen.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FLAGGED = 1'b1
    } flag_st_e;

    localparam int unsigned N_COPIES = 3;

endpackage

// File: rtl/tmr_tff_bank.sv
module tmr_tff_bank #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tgl,
    input  logic [W-1:0] inj,
    output logic [W-1:0] st,
    output logic [W-1:0] dout
);

    logic [W-1:0] st_q;

    // one toggle flip-flop per bit; the inversion never reaches the state
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_q ^ tgl;
        end
    end

    assign st   = st_q;
    assign dout = st_q ^ inj;

endmodule

// File: rtl/tmr_mux_voter.sv
module tmr_mux_voter #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cp_a,
    input  logic [W-1:0] cp_b,
    input  logic [W-1:0] cp_c,
    output logic [W-1:0] voted,
    output logic [W-1:0] dis_bits,
    output logic         dis_any
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sel;
        logic       v_bit;
        logic       e_bit;

        assign sel = {cp_b[i], cp_c[i]};

        // data mux: B and C select, A breaks the tie
        always_comb begin
            unique case (sel)
                2'b00:        v_bit = 1'b0;
                2'b01, 2'b10: v_bit = cp_a[i];
                2'b11:        v_bit = 1'b1;
                default:      v_bit = 1'b0;
            endcase
        end

        // flag mux: disagreement between B and C, or A against their common value
        always_comb begin
            unique case (sel)
                2'b00:        e_bit = cp_a[i];
                2'b01, 2'b10: e_bit = 1'b1;
                2'b11:        e_bit = ~cp_a[i];
                default:      e_bit = 1'b0;
            endcase
        end

        assign voted[i]    = v_bit;
        assign dis_bits[i] = e_bit;
    end

    assign dis_any = |dis_bits;

endmodule

// File: rtl/tmr_flag_fsm.sv
module tmr_flag_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_in,
    input  logic clr_in,
    output logic flag
);

    flag_st_e state_q;
    flag_st_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_CLEAN;
        end else begin
            state_q <= state_d;
        end
    end

    // a set in the same cycle as a clear keeps the flag
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAN: begin
                if (set_in) state_d = ST_FLAGGED;
            end
            ST_FLAGGED: begin
                if (clr_in && !set_in) state_d = ST_CLEAN;
            end
            default: state_d = ST_CLEAN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_CLEAN:   flag = 1'b0;
            ST_FLAGGED: flag = 1'b1;
            default:    flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_toggle_reg.sv
module tmr_toggle_reg
    import tmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] tgl,
    input  logic [W-1:0] inj_a,
    input  logic [W-1:0] inj_b,
    input  logic [W-1:0] inj_c,
    input  logic         clr_flag,
    output logic [W-1:0] q,
    output logic         mismatch,
    output logic         mismatch_seen
);

    logic [N_COPIES-1:0][W-1:0] inj_v;
    logic [N_COPIES-1:0][W-1:0] copy_st;
    logic [N_COPIES-1:0][W-1:0] copy_out;
    logic [W-1:0]               dis_bits;

    assign inj_v[0] = inj_a;
    assign inj_v[1] = inj_b;
    assign inj_v[2] = inj_c;

    for (genvar k = 0; k < N_COPIES; k++) begin : g_copy
        tmr_tff_bank #(.W(W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .tgl  (tgl),
            .inj  (inj_v[k]),
            .st   (copy_st[k]),
            .dout (copy_out[k])
        );
    end

    tmr_mux_voter #(.W(W)) u_voter (
        .cp_a     (copy_out[0]),
        .cp_b     (copy_out[1]),
        .cp_c     (copy_out[2]),
        .voted    (q),
        .dis_bits (dis_bits),
        .dis_any  (mismatch)
    );

    tmr_flag_fsm u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_in (mismatch),
        .clr_in (clr_flag),
        .flag   (mismatch_seen)
    );

endmodule

// File: rtl/tmr_toggle_reg_chk.sv
module tmr_toggle_reg_chk #(
    parameter int unsigned W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [W-1:0]       tgl,
    input logic [W-1:0]       inj_a,
    input logic [W-1:0]       inj_b,
    input logic [W-1:0]       inj_c,
    input logic               clr_flag,
    input logic [W-1:0]       q,
    input logic               mismatch,
    input logic               mismatch_seen,
    input logic [2:0][W-1:0]  copy_st,
    input logic [2:0][W-1:0]  copy_out
);

    logic         no_inj;
    logic         single_fault;
    logic [W-1:0] maj_out;
    logic         rst_d;

    assign no_inj       = ~|(inj_a | inj_b | inj_c);
    assign single_fault = ~|((inj_a & inj_b) | (inj_b & inj_c) | (inj_a & inj_c));
    assign maj_out      = (copy_out[0] & copy_out[1]) | (copy_out[1] & copy_out[2])
                        | (copy_out[0] & copy_out[2]);

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d === 1'b1 && !rst && no_inj) begin
            AST_RESET_CLEAR: assert (q == '0 && !mismatch_seen); // R1
        end
    end

    AST_TOGGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && no_inj && $past(no_inj)) |-> (q == ($past(q) ^ $past(tgl)))); // R2

    AST_MAJORITY: assert property (@(posedge clk) disable iff (rst)
        q == maj_out); // R3

    AST_SINGLE_MASK: assert property (@(posedge clk) disable iff (rst)
        single_fault |-> (q == copy_st[0])); // R4

    AST_DISAGREE: assert property (@(posedge clk) disable iff (rst)
        mismatch == |((copy_out[0] ^ copy_out[1]) | (copy_out[1] ^ copy_out[2]))); // R6

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> mismatch_seen); // R8

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mismatch_seen && !clr_flag) |=> mismatch_seen); // R8

    AST_CLEAN_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!mismatch_seen && !mismatch) |=> !mismatch_seen); // R10

endmodule

bind tmr_toggle_reg tmr_toggle_reg_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tgl           (tgl),
    .inj_a         (inj_a),
    .inj_b         (inj_b),
    .inj_c         (inj_c),
    .clr_flag      (clr_flag),
    .q             (q),
    .mismatch      (mismatch),
    .mismatch_seen (mismatch_seen),
    .copy_st       (copy_st),
    .copy_out      (copy_out)
);

// File: tb/tmr_toggle_reg_tb.sv
module tmr_toggle_reg_tb;

    localparam int W      = 8;
    localparam int CLK_PD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] tgl, inj_a, inj_b, inj_c;
    logic         clr_flag;
    logic [W-1:0] q;
    logic         mismatch, mismatch_seen;

    int           n_checks = 0;
    int           n_errors = 0;
    logic [W-1:0] ref_st;
    logic         ref_flag;

    always #(CLK_PD/2) clk = ~clk;

    tmr_toggle_reg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .tgl(tgl), .inj_a(inj_a), .inj_b(inj_b), .inj_c(inj_c),
        .clr_flag(clr_flag), .q(q), .mismatch(mismatch), .mismatch_seen(mismatch_seen)
    );

    function automatic logic [W-1:0] exp_q(logic [W-1:0] s, logic [W-1:0] a,
                                           logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] oa, ob, oc;
        oa = s ^ a; ob = s ^ b; oc = s ^ c;
        return (oa & ob) | (ob & oc) | (oa & oc);
    endfunction

    function automatic logic exp_mis(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        return |((a ^ b) | (b ^ c));
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive after falling edge, sample 1 unit later, then advance model at rising edge
    task automatic step(logic [W-1:0] t, logic [W-1:0] a, logic [W-1:0] b,
                        logic [W-1:0] c, logic cl, string tq, string tf);
        logic em;
        tgl = t; inj_a = a; inj_b = b; inj_c = c; clr_flag = cl; rst = 1'b0;
        #1;
        em = exp_mis(a, b, c);
        chk(tq, q, exp_q(ref_st, a, b, c));
        chk("R6", {{(W-1){1'b0}}, mismatch}, {{(W-1){1'b0}}, em});
        chk(tf, {{(W-1){1'b0}}, mismatch_seen}, {{(W-1){1'b0}}, ref_flag});
        @(posedge clk);
        ref_st = ref_st ^ t;
        if (em) ref_flag = 1'b1;
        else if (cl) ref_flag = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PD * 200000);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb, rc, rt, pick;
        void'($urandom(32'd4242));
        rst = 1'b1; tgl = '1; inj_a = '0; inj_b = '0; inj_c = '0; clr_flag = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ref_st = '0; ref_flag = 1'b0;

        // R1: state after reset, toggles were held high during reset
        step('0, '0, '0, '0, 1'b0, "R1", "R1");

        // R2: toggle patterns, no faults
        step('1, '0, '0, '0, 1'b0, "R2", "R8");
        step(8'hA5, '0, '0, '0, 1'b0, "R2", "R8");
        step('0, '0, '0, '0, 1'b0, "R2", "R8");
        step(8'h0F, '0, '0, '0, 1'b0, "R2", "R8");
        chk("R2", q, 8'h5A ^ 8'h0F);

        // R4: single copy fully inverted, each copy in turn; toggling continues (R5)
        step(8'h33, '1, '0, '0, 1'b0, "R4", "R8");
        step(8'h11, '0, '1, '0, 1'b0, "R4", "R8");
        step(8'h80, '0, '0, '1, 1'b1, "R4", "R9");
        // R5: faults removed, q shows full toggle history
        step('0, '0, '0, '0, 1'b0, "R5", "R9");
        chk("R5", q, 8'h55 ^ 8'h33 ^ 8'h11 ^ 8'h80);

        // R8: clear with no live mismatch drops the flag
        step('0, '0, '0, '0, 1'b1, "R3", "R8");
        step('0, '0, '0, '0, 1'b0, "R3", "R8");
        // R10: clear while clean
        step('0, '0, '0, '0, 1'b1, "R3", "R10");
        step('0, '0, '0, '0, 1'b0, "R3", "R10");

        // R7: two copies inverted on the same bits
        step('0, 8'h0F, 8'h0F, '0, 1'b0, "R7", "R8");
        chk("R7", q, ref_st ^ 8'h0F);
        step('0, 8'hF0, '0, 8'hF0, 1'b0, "R7", "R8");
        step('0, '0, '0, '0, 1'b1, "R5", "R8");
        step('0, '0, '0, '0, 1'b0, "R5", "R8");

        // constrained random: single-fault masks (R4) and arbitrary masks (R3)
        for (int n = 0; n < 3000; n++) begin
            rt = W'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                ra = '0; rb = '0; rc = '0;
                pick = W'($urandom);
                for (int i = 0; i < W; i++) begin
                    if (pick[i]) begin
                        case ($urandom_range(0, 2))
                            0: ra[i] = 1'b1;
                            1: rb[i] = 1'b1;
                            default: rc[i] = 1'b1;
                        endcase
                    end
                end
                step(rt, ra, rb, rc, ($urandom_range(0, 7) == 0), "R4", "R8");
            end else begin
                ra = W'($urandom) & W'($urandom);
                rb = W'($urandom) & W'($urandom);
                rc = W'($urandom) & W'($urandom);
                step(rt, ra, rb, rc, ($urandom_range(0, 3) == 0), "R3", "R9");
            end
        end

        // R1: reset mid-run clears everything
        rst = 1'b1; tgl = '1; inj_a = '0; inj_b = '0; inj_c = '0; clr_flag = 1'b0;
        @(posedge clk);
        @(negedge clk);
        ref_st = '0; ref_flag = 1'b0;
        step('0, '0, '0, '0, 1'b0, "R1", "R1");

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule